// File: doc/BRIEF.md
# Configurable GPIO Port with Edge Interrupts

This block is one general-purpose I/O port of parameterised width, eight pins by default. Software reaches it through a simple register bus. Through that bus it sets an output data word, a 2-bit port mode, and a per-pin interrupt-enable mask. The mode code controls two things. It picks the driver style for every pin: open drain, resistive pull-up, or push-pull CMOS. It also picks which edge direction raises an interrupt. The block turns the data word and the mode into three per-pin pad controls: a low-side driver enable, a high-side driver enable and a pull-up enable.

Pin levels pass through a synchronizer before use. A read of the data address returns these synchronized levels, not the value last written. Enabled edges on the synchronized pins set one sticky pending flag, and the interrupt request output follows that flag. Software clears the flag by writing to the status address. In the open-drain and resistive modes a data bit of 1 releases the pin, so external logic can pull it and the pin can serve as an input.

Top module: `gpio_edge_port`

## Requirements
- R1: After a synchronous active-low reset, the data word is all ones, the mode is code 00, the enable mask is zero and the pending flag is clear. As a result no pin drives low or high, no pull-up is on, and irq is low.
- R2: In modes 00 and 01 (open drain), pin_drive_low is the inverse of the data word, and pin_drive_high and pin_pullup_en are zero.
- R3: In mode 10 (CMOS), pin_drive_low is the inverse of the data word, pin_drive_high equals the data word, and pin_pullup_en is zero.
- R4: In mode 11 (resistive), pin_pullup_en equals the data word, pin_drive_low is its inverse, and pin_drive_high is zero.
- R5: A read at address 0 returns pin_in as captured two rising edges earlier (two-flop synchronizer). It never returns the written data word.
- R6: Address 1 reads the mode in bits 1:0 with zeros above. Address 2 reads the enable mask. Address 3 reads the pending flag in bit 0 with zeros above. Writes to addresses 0, 1 and 2 load the data word, the mode and the mask.
- R7: In mode 00, a 0-to-1 change on an enabled pin sets the pending flag. irq goes high on the third rising edge after the pin changes.
- R8: In modes 01 and 11, a 1-to-0 change on an enabled pin sets the pending flag, with the same latency as R7.
- R9: Edges on pins whose enable bit is 0 have no effect on the pending flag.
- R10: In mode 10, no edge sets the pending flag, whatever the enable mask holds.
- R11: The pending flag stays set until a write to address 3 with bit 0 = 1. A write to address 3 with bit 0 = 0 leaves it unchanged.
- R12: When a new enabled edge and a clearing write fall on the same clock edge, the flag ends up set.
- R13: An edge in the direction opposite to the selected polarity has no effect on the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 2 | Register address (0 data, 1 mode, 2 mask, 3 status) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Pin levels from the pads |
| pin_drive_low | output | 8 | Per-pin low-side driver enable |
| pin_drive_high | output | 8 | Per-pin high-side driver enable |
| pin_pullup_en | output | 8 | Per-pin pull-up enable |
| irq | output | 1 | Interrupt request, follows the pending flag |

## Verification
The bench checks polarity against all four mode codes. It drives both edge directions in each mode. A design that decoded code 11 as rising-edge, or that left CMOS interrupts live, would raise irq where the model expects none. It times irq against the third clock edge after a pin change, so a design with a missing or extra synchronizer stage is off by one cycle. It also lands a clearing write on the same edge as a new enabled edge, which catches a design where the clear wins over the set. A read at the data address while the data word and the pins hold different values exposes a design that returns the register instead of the pins.

// File: rtl/gpio_port_pkg.sv
// Package: shared mode codes and register addresses for the GPIO port.
// Assumes a 2-bit register address space; the mode codes are decoded by
// software, so their values are fixed.
package gpio_port_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        MODE_OD_RISE   = 2'b00,
        MODE_OD_FALL   = 2'b01,
        MODE_PUSHPULL  = 2'b10,
        MODE_RESISTIVE = 2'b11
    } port_mode_e;

    localparam logic [ADDR_W-1:0] REG_DATA   = 2'd0;
    localparam logic [ADDR_W-1:0] REG_MODE   = 2'd1;
    localparam logic [ADDR_W-1:0] REG_IEN    = 2'd2;
    localparam logic [ADDR_W-1:0] REG_STATUS = 2'd3;

endpackage

// File: rtl/gpio_pin_sync.sv
// Module: multi-stage synchronizer for the pad inputs.
// Assumes pin_in is asynchronous to clk; STAGES >= 2. The output is the last
// stage and resets to zero.
module gpio_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pad level
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                // Pass the level one stage further
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_drive_ctrl.sv
// Module: turns the data word and port mode into per-pin pad controls.
// Assumes combinational use; a data bit of 1 releases the pin except in
// push-pull mode, where it drives high.
module gpio_drive_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_word,
    input  port_mode_e       mode,
    output logic [WIDTH-1:0] drive_low,
    output logic [WIDTH-1:0] drive_high,
    output logic [WIDTH-1:0] pullup_en
);

    // Select the pad control pattern for the active mode
    always_comb begin
        drive_low  = ~data_word;
        drive_high = '0;
        pullup_en  = '0;
        unique case (mode)
            MODE_PUSHPULL:  drive_high = data_word;
            MODE_RESISTIVE: pullup_en  = data_word;
            default:        ;
        endcase
    end

endmodule

// File: rtl/gpio_edge_irq.sv
// Module: per-pin edge detectors feeding one sticky pending flag.
// Assumes level is already synchronized. Polarity and the push-pull mask
// come from the mode; a new set wins over a clear in the same cycle.
module gpio_edge_irq
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] enable_mask,
    input  port_mode_e       mode,
    input  logic             clear_req,
    output logic             set_event,
    output logic             pending
);

    logic [WIDTH-1:0] level_prev_q;
    logic [WIDTH-1:0] rise_vec;
    logic [WIDTH-1:0] fall_vec;
    logic [WIDTH-1:0] hit_vec;
    logic             pend_q;

    // Remember the previous synchronized sample
    always_ff @(posedge clk) begin
        if (!rst_n) level_prev_q <= '0;
        else        level_prev_q <= level;
    end

    // Pick the edge direction named by the mode and apply the enable mask
    always_comb begin
        rise_vec = level & ~level_prev_q;
        fall_vec = ~level & level_prev_q;
        unique case (mode)
            MODE_OD_RISE:  hit_vec = rise_vec & enable_mask;
            MODE_PUSHPULL: hit_vec = '0;
            default:       hit_vec = fall_vec & enable_mask;
        endcase
    end

    assign set_event = |hit_vec;

    // Sticky pending flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (set_event) pend_q <= 1'b1;
        else if (clear_req) pend_q <= 1'b0;
    end

    assign pending = pend_q;

endmodule

// File: rtl/gpio_edge_port.sv
// Module: top of the GPIO port; holds the data, mode and mask registers,
// decodes the register bus and connects the drive, sync and interrupt parts.
// Assumes a single-cycle write strobe and combinational read data.
module gpio_edge_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_drive_low,
    output logic [WIDTH-1:0]  pin_drive_high,
    output logic [WIDTH-1:0]  pin_pullup_en,
    output logic              irq
);

    localparam int MODE_W = $bits(port_mode_e);

    logic [WIDTH-1:0] data_q;
    port_mode_e       mode_q;
    logic [WIDTH-1:0] ien_q;
    logic [WIDTH-1:0] pin_sync;
    logic             clear_req;
    logic             irq_set;
    logic             pending;

    // Register writes from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '1;
            mode_q <= MODE_OD_RISE;
            ien_q  <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                REG_DATA: data_q <= bus_wdata;
                REG_MODE: mode_q <= port_mode_e'(bus_wdata[MODE_W-1:0]);
                REG_IEN:  ien_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    assign clear_req = bus_wr && (bus_addr == REG_STATUS) && bus_wdata[0];

    // Read mux: pins, mode, mask or status
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_DATA:   bus_rdata = pin_sync;
            REG_MODE:   bus_rdata[MODE_W-1:0] = mode_q;
            REG_IEN:    bus_rdata = ien_q;
            REG_STATUS: bus_rdata[0] = pending;
            default:    ;
        endcase
    end

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_drive_ctrl #(.WIDTH(WIDTH)) u_drive (
        .data_word  (data_q),
        .mode       (mode_q),
        .drive_low  (pin_drive_low),
        .drive_high (pin_drive_high),
        .pullup_en  (pin_pullup_en)
    );

    gpio_edge_irq #(.WIDTH(WIDTH)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (pin_sync),
        .enable_mask (ien_q),
        .mode        (mode_q),
        .clear_req   (clear_req),
        .set_event   (irq_set),
        .pending     (pending)
    );

    assign irq = pending;

endmodule

// File: rtl/gpio_edge_port_chk.sv
// Module: assertion checker bound to gpio_edge_port.
// Assumes visibility of the mode register and the interrupt set event.
module gpio_edge_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] pin_drive_low,
    input logic [WIDTH-1:0] pin_drive_high,
    input logic [WIDTH-1:0] pin_pullup_en,
    input logic             irq,
    input logic [1:0]       mode_q,
    input logic             irq_set
);

    logic clr_w;
    assign clr_w = bus_wr && (bus_addr == 2'd3) && bus_wdata[0];

    // R3: only push-pull mode may drive a pin high
    a_r3_high_only_cmos: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'b10) |-> (pin_drive_high == '0));

    // R4: a pin is never pulled up and driven low at once
    a_r4_pull_not_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pullup_en & pin_drive_low) == '0);

    // R2: high and low drivers never fight
    a_r2_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_drive_high & pin_drive_low) == '0);

    // R10: push-pull mode never raises a new request
    a_r10_cmos_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b10 && !irq) |=> !irq);

    // R11: pending stays until a clearing write
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_w) |=> irq);

    // R12: a set event always leaves the flag set
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq);

    // R11: a clear with no competing set drops the flag
    a_r11_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && !irq_set) |=> !irq);

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .pin_drive_low  (pin_drive_low),
    .pin_drive_high (pin_drive_high),
    .pin_pullup_en  (pin_pullup_en),
    .irq            (irq),
    .mode_q         (mode_q),
    .irq_set        (irq_set)
);

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_drive_low;
    logic [7:0] pin_drive_high;
    logic [7:0] pin_pullup_en;
    logic       irq;

    int    errs = 0;
    int    checks = 0;
    bit    done = 0;
    string phase = "R1";

    // behavioural model state
    logic [7:0] hist[$];
    logic [7:0] m_data, m_ien;
    logic [1:0] m_mode;
    bit         m_pend;

    always #(PERIOD/2) clk = ~clk;

    gpio_edge_port uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_drive_low(pin_drive_low), .pin_drive_high(pin_drive_high),
        .pin_pullup_en(pin_pullup_en), .irq(irq)
    );

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, act, exp, $time);
        end
    endtask

    // Model update on each edge, then compare a quarter period later
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{8'h00, 8'h00, 8'h00, 8'h00};
            m_data = 8'hFF; m_mode = 2'b00; m_ien = 8'h00; m_pend = 0;
        end else begin
            logic [7:0] cur, old, hits;
            bit setv, clrv;
            hist.push_front(pin_in);
            void'(hist.pop_back());
            cur = hist[2];
            old = hist[3];
            case (m_mode)
                2'b00:   hits = cur & ~old & m_ien;
                2'b10:   hits = 8'h00;
                default: hits = ~cur & old & m_ien;
            endcase
            setv = (hits != 0);
            clrv = bus_wr && bus_addr == 2'd3 && bus_wdata[0];
            if (bus_wr) begin
                if (bus_addr == 2'd0) m_data = bus_wdata;
                if (bus_addr == 2'd1) m_mode = bus_wdata[1:0];
                if (bus_addr == 2'd2) m_ien = bus_wdata;
            end
            m_pend = setv ? 1'b1 : (clrv ? 1'b0 : m_pend);
        end
        #(PERIOD/4);
        if (!done) begin
            logic [7:0] exp_rd;
            case (bus_addr)
                2'd0: exp_rd = hist[1];
                2'd1: exp_rd = {6'b0, m_mode};
                2'd2: exp_rd = m_ien;
                default: exp_rd = {7'b0, m_pend};
            endcase
            check("drive_low", pin_drive_low, ~m_data);
            check("drive_high", pin_drive_high, (m_mode == 2'b10) ? m_data : 8'h00);
            check("pullup", pin_pullup_en, (m_mode == 2'b11) ? m_data : 8'h00);
            check("irq", {7'b0, irq}, {7'b0, m_pend});
            check("rdata", bus_rdata, exp_rd);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        errs++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        phase = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(3);

        phase = "R2";
        wr(2'd0, 8'h5A); idle(2);
        wr(2'd1, 8'h01); idle(2);

        phase = "R3";
        wr(2'd1, 8'h02); wr(2'd0, 8'hA5); idle(2);

        phase = "R4";
        wr(2'd1, 8'h03); wr(2'd0, 8'h3C); idle(2);

        phase = "R5";
        bus_addr = 2'd0;
        pins(8'hC3); idle(4);
        pins(8'h18); idle(1); pins(8'h81); idle(4);

        phase = "R6";
        wr(2'd2, 8'h0F); bus_addr = 2'd1; idle(1);
        bus_addr = 2'd2; idle(1); bus_addr = 2'd3; idle(1);

        phase = "R7";
        wr(2'd1, 8'h00);
        pins(8'h00); idle(4);
        pins(8'h01); idle(5);
        wr(2'd3, 8'h01); idle(2);

        phase = "R13";
        pins(8'h00); idle(5);

        phase = "R8";
        wr(2'd1, 8'h01);
        pins(8'h02); idle(4); pins(8'h00); idle(5);
        wr(2'd3, 8'h01);
        wr(2'd1, 8'h03);
        pins(8'h04); idle(4); pins(8'h00); idle(5);
        wr(2'd3, 8'h01);

        phase = "R9";
        wr(2'd1, 8'h00);
        pins(8'hF0); idle(4); pins(8'h00); idle(5);

        phase = "R10";
        wr(2'd1, 8'h02); wr(2'd2, 8'hFF);
        pins(8'hFF); idle(4); pins(8'h00); idle(5);

        phase = "R11";
        wr(2'd1, 8'h00);
        pins(8'h08); idle(5);
        wr(2'd3, 8'h00); idle(3);
        wr(2'd3, 8'h01); idle(2);

        phase = "R12";
        pins(8'h00); idle(4);
        pins(8'h10);
        idle(1);
        wr(2'd3, 8'h01);
        idle(3);
        wr(2'd3, 8'h01); idle(2);

        finish_run();
    end

endmodule